// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Timing

This block is a 36-bit first-in first-out buffer whose write side and read side run on two independent clocks. Each side moves a word on a rising edge of its own clock when its active-low select is low and its enable is high. Each pointer crosses into the other clock domain as a gray code through a two-flop synchronizer. Because of that, the boundary flags seen on one side can trail activity on the other side by a few cycles.

A timing-select input is captured while master reset is held and picks one of two read behaviours. In standard timing, a read request loads the next stored word into a registered output, and the read-side ready flag means "not empty". In fall-through timing, the oldest word is placed on the output without any request, the ready flag means "output valid", and a read request consumes that word. Each side also has an active-low almost-boundary flag. Their offsets are chosen during master reset from three presets.

Partial reset empties the buffer, clears the output register and leaves the captured configuration unchanged. In standard timing, a retransmit strobe rewinds the read pointer to location zero so that the stored sequence can be read again.

Top module: `dcf_fifo`

## Requirements
- R1: A write happens on a rising `wclk` edge only when `wcs_n`=0 and `wen`=1. A read request happens on a rising `rclk` edge only when `rcs_n`=0 and `ren`=1. No other combination changes any pointer or the output.
- R2: In standard timing (`timing_sel`=0), an accepted read loads the next word, in write order, into `rdata` at that `rclk` edge. `rd_rdy` is 1 exactly when words are stored.
- R3: Once DEPTH words are stored, `wr_rdy` goes to 0 and further writes are dropped. A read request when no word is stored or ready leaves `rdata` and the pointers unchanged.
- R4: In fall-through timing (`timing_sel`=1), the oldest stored word appears on `rdata` with `rd_rdy`=1 without a read request. Each read request consumes the displayed word and shows the next one. When no word remains, `rd_rdy` falls and `rdata` keeps the last word.
- R5: `rae_n`, timed by `rclk`, is 0 when the stored word count (including a displayed fall-through word) is at or below the empty-side offset.
- R6: `waf_n`, timed by `wclk`, is 0 when the number of free locations is at or below the full-side offset.
- R7: While `mrst_n`=0, `ofs_sel` sets both offsets: 00 gives 8 words, 01 gives 16 words, and 10 or 11 gives 64 words. `timing_sel` is captured during the same reset.
- R8: Master reset empties the buffer and gives `rdata`=0, `rd_rdy`=0, `wr_rdy`=1, `rae_n`=0 and `waf_n`=1.
- R9: Partial reset (`prst_n`=0) produces the same empty state as R8, but it keeps the timing selection and the offsets, whatever `ofs_sel` is at that time.
- R10: In standard timing, `rtx_n`=0 at a rising `rclk` edge moves the read pointer to location zero. In fall-through timing the strobe has no effect.
- R11: The write pointer crosses to the read domain as a gray code, with at most one bit changing per `wclk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wcs_n | input | 1 | Write select, active low |
| wen | input | 1 | Write enable |
| wdata | input | 36 | Write data |
| wr_rdy | output | 1 | Space available (not full) |
| waf_n | output | 1 | Almost full, active low |
| rclk | input | 1 | Read-side clock |
| rcs_n | input | 1 | Read select, active low |
| ren | input | 1 | Read enable |
| rdata | output | 36 | Registered read data |
| rd_rdy | output | 1 | Not empty (standard) or output valid (fall-through) |
| rae_n | output | 1 | Almost empty, active low |
| mrst_n | input | 1 | Master reset, active low, captures configuration |
| prst_n | input | 1 | Partial reset, active low, keeps configuration |
| timing_sel | input | 1 | 0 standard, 1 fall-through; captured in master reset |
| ofs_sel | input | 2 | Offset preset select, captured in master reset |
| rtx_n | input | 1 | Retransmit strobe, active low, read clock |

## Verification
The hardest conditions to reach are the ones at the far edges of the buffer: a completely full memory with extra writes pushed at it, and the exact one-word steps across each almost-boundary under each offset preset. A vector table drives bursts of writes and reads in a fixed order that walks the fill level to 120, 121 and 128 words, then down to 8 and to 0. The bench waits for the synchronizers to settle before it compares the flags. Separate directed sequences show that the configuration survives a partial reset by changing `ofs_sel` during that reset. Other directed sequences start a retransmit in each timing mode partway through a stream.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // preset offset: 00 -> 8, 01 -> 16, 1x -> 64
  function automatic int unsigned preset_offset(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [1:0]  ofs_sel,
  input  logic        cs_n,
  input  logic        en,
  input  logic [AW:0] rgray_sync,
  output logic [AW:0] wgray,
  output logic [AW-1:0] waddr,
  output logic        wr_acc,
  output logic [AW:0] wfill,
  output logic        wr_rdy,
  output logic        af_n
);
  import dcf_pkg::*;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr, wptr_n, rbin, fill_n, y_q;

  always_ff @(posedge clk)
    if (cfg_load) y_q <= PW'(preset_offset(ofs_sel));

  assign wr_acc = !cs_n && en && wr_rdy;
  assign wptr_n = wptr + PW'(wr_acc);
  assign rbin   = PW'(gray2bin(32'(rgray_sync)));
  assign fill_n = wptr_n - rbin;
  assign wfill  = wptr - rbin;
  assign waddr  = wptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      wr_rdy <= 1'b1;
      af_n   <= 1'b1;
    end else begin
      wptr   <= wptr_n;
      wgray  <= PW'(bin2gray(32'(wptr_n)));
      wr_rdy <= fill_n != PW'(DEPTH);
      af_n   <= !((PW'(DEPTH) - fill_n) <= y_q);
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int AW = 7,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    ofs_sel,
  input  logic          timing_sel,
  input  logic          cs_n,
  input  logic          en,
  input  logic          rtx_n,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] mem_rd,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          fetch,
  output logic [DW-1:0] rdata,
  output logic          rd_rdy,
  output logic          ae_n
);
  import dcf_pkg::*;
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr, rptr_n, wbin, cnt_n, x_q;
  logic          fwft_q, or_q, or_n, rd_req, has_word, rtx;

  always_ff @(posedge clk)
    if (cfg_load) begin
      x_q    <= PW'(preset_offset(ofs_sel));
      fwft_q <= timing_sel;
    end

  assign wbin     = PW'(gray2bin(32'(wgray_sync)));
  assign has_word = rptr != wbin;
  assign rd_req   = !cs_n && en;
  assign rtx      = !fwft_q && !rtx_n;
  assign fetch    = fwft_q ? (has_word && (!or_q || rd_req))
                           : (has_word && rd_req && rd_rdy);
  assign or_n     = fwft_q && (fetch || (or_q && !rd_req));
  assign rptr_n   = rtx ? '0 : rptr + PW'(fetch);
  assign cnt_n    = wbin - rptr_n + PW'(or_n);
  assign raddr    = rptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      or_q   <= 1'b0;
      rd_rdy <= 1'b0;
      ae_n   <= 1'b0;
      rdata  <= '0;
    end else begin
      rptr   <= rptr_n;
      rgray  <= PW'(bin2gray(32'(rptr_n)));
      or_q   <= or_n;
      rd_rdy <= fwft_q ? or_n : (rptr_n != wbin);
      ae_n   <= !(cnt_n <= x_q);
      if (fetch) rdata <= mem_rd;
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int AW = 7,
  parameter int DW = 36
) (
  input  logic          wclk,
  input  logic          wcs_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wr_rdy,
  output logic          waf_n,
  input  logic          rclk,
  input  logic          rcs_n,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rd_rdy,
  output logic          rae_n,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          timing_sel,
  input  logic [1:0]    ofs_sel,
  input  logic          rtx_n
);
  localparam int DEPTH = 1 << AW;

  logic          ptr_rst_n, wr_acc, rfetch;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s, wfill;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem [DEPTH];

  assign ptr_rst_n = mrst_n && prst_n;

  always_ff @(posedge wclk)
    if (wr_acc) mem[waddr] <= wdata;

  dcf_sync #(.W(AW+1), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(ptr_rst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(AW+1), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(ptr_rst_n), .d(rgray), .q(rgray_s));

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk(wclk), .rst_n(ptr_rst_n), .cfg_load(!mrst_n), .ofs_sel(ofs_sel),
    .cs_n(wcs_n), .en(wen), .rgray_sync(rgray_s), .wgray(wgray),
    .waddr(waddr), .wr_acc(wr_acc), .wfill(wfill), .wr_rdy(wr_rdy), .af_n(waf_n));

  dcf_rd_side #(.AW(AW), .DW(DW)) u_rd (
    .clk(rclk), .rst_n(ptr_rst_n), .cfg_load(!mrst_n), .ofs_sel(ofs_sel),
    .timing_sel(timing_sel), .cs_n(rcs_n), .en(ren), .rtx_n(rtx_n),
    .wgray_sync(wgray_s), .mem_rd(mem[raddr]), .raddr(raddr), .rgray(rgray),
    .fetch(rfetch), .rdata(rdata), .rd_rdy(rd_rdy), .ae_n(rae_n));
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int AW = 7,
  parameter int DW = 36
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic [AW:0]   wgray,
  input logic [AW:0]   wfill,
  input logic          wr_rdy,
  input logic          waf_n,
  input logic          rfetch,
  input logic [DW-1:0] rdata,
  input logic          rd_rdy,
  input logic          rae_n
);
  localparam int DEPTH = 1 << AW;

  a_r11_gray_step: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));

  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    wfill <= (AW+1)'(DEPTH));

  a_r6_full_is_almost_full: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_rdy |-> !waf_n);

  a_r5_empty_is_almost_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_rdy |-> !rae_n);

  a_r3_output_held: assert property (@(posedge rclk) disable iff (!rst_n)
    !rfetch |=> $stable(rdata));
endmodule

bind dcf_fifo dcf_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(ptr_rst_n), .wgray(wgray), .wfill(wfill),
  .wr_rdy(wr_rdy), .waf_n(waf_n), .rfetch(rfetch), .rdata(rdata),
  .rd_rdy(rd_rdy), .rae_n(rae_n));

// File: tb/sim_dcf_fifo.sv
module sim_dcf_fifo;
  localparam int DEPTH = 128;

  logic wclk = 0, rclk = 0;
  logic wcs_n = 1, wen = 0, rcs_n = 1, ren = 0;
  logic [35:0] wdata = '0;
  logic mrst_n = 0, prst_n = 1, timing_sel = 0, rtx_n = 1;
  logic [1:0] ofs_sel = 0;
  logic wr_rdy, waf_n, rd_rdy, rae_n;
  logic [35:0] rdata;

  int n_chk = 0, n_bad = 0;
  int wseq = 0, rseq = 0, mcnt = 0;
  logic [35:0] last_rd = '0;
  bit done = 0;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  dcf_fifo u0 (.wclk(wclk), .wcs_n(wcs_n), .wen(wen), .wdata(wdata),
    .wr_rdy(wr_rdy), .waf_n(waf_n), .rclk(rclk), .rcs_n(rcs_n), .ren(ren),
    .rdata(rdata), .rd_rdy(rd_rdy), .rae_n(rae_n), .mrst_n(mrst_n),
    .prst_n(prst_n), .timing_sel(timing_sel), .ofs_sel(ofs_sel), .rtx_n(rtx_n));

  // words written, bursts read, flags {rd_rdy, wr_rdy, rae_n, waf_n}
  localparam logic [19:0] VEC [10] = '{
    {8'd4,   8'd0,   4'b1101}, {8'd5,   8'd0,   4'b1111},
    {8'd0,   8'd1,   4'b1101}, {8'd112, 8'd0,   4'b1110},
    {8'd1,   8'd0,   4'b1110}, {8'd7,   8'd0,   4'b1010},
    {8'd3,   8'd0,   4'b1010}, {8'd0,   8'd120, 4'b1101},
    {8'd0,   8'd8,   4'b0101}, {8'd0,   8'd2,   4'b0101}};

  function automatic logic [35:0] pat(input int s);
    return 36'(s) ^ 36'h5A5A5A5A5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act,
                     input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge wclk);
    repeat (8) @(posedge rclk);
    @(negedge rclk); #1;
  endtask

  task automatic do_mreset(input logic mode, input logic [1:0] sel);
    @(negedge wclk);
    mrst_n = 0; timing_sel = mode; ofs_sel = sel;
    repeat (4) @(posedge rclk);
    @(negedge wclk); mrst_n = 1;
    wseq = 0; rseq = 0; mcnt = 0; last_rd = '0;
    settle();
  endtask

  task automatic wr_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); wcs_n = 0; wen = 1; wdata = pat(wseq);
      @(posedge wclk);
      if (mcnt < DEPTH) begin wseq++; mcnt++; end
    end
    @(negedge wclk); wcs_n = 1; wen = 0;
  endtask

  task automatic rd_burst(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); rcs_n = 0; ren = 1;
      @(posedge rclk); #1;
      if (mcnt > 0) begin last_rd = pat(rseq); rseq++; mcnt--; end
      chk(rdata == last_rd, req, rdata, last_rd);
    end
    @(negedge rclk); rcs_n = 1; ren = 0;
  endtask

  task automatic fw_read(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      chk(rd_rdy == 1'b1, "R4", 36'(rd_rdy), 36'd1);
      chk(rdata == pat(rseq), "R4", rdata, pat(rseq));
      rcs_n = 0; ren = 1;
      @(posedge rclk);
      last_rd = pat(rseq); rseq++; mcnt--;
    end
    @(negedge rclk); rcs_n = 1; ren = 0;
  endtask

  task automatic chk_flags(input logic [3:0] f);
    chk(rd_rdy == f[3], "R2", 36'(rd_rdy), 36'(f[3]));
    chk(wr_rdy == f[2], "R3", 36'(wr_rdy), 36'(f[2]));
    chk(rae_n  == f[1], "R5", 36'(rae_n),  36'(f[1]));
    chk(waf_n  == f[0], "R6", 36'(waf_n),  36'(f[0]));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    do_mreset(0, 2'b00);
    chk(rdata == '0, "R8", rdata, '0);
    chk({rd_rdy, wr_rdy, rae_n, waf_n} == 4'b0101, "R8",
        36'({rd_rdy, wr_rdy, rae_n, waf_n}), 36'h5);

    // R1 select/enable gating
    @(negedge wclk); wcs_n = 1; wen = 1; repeat (3) @(negedge wclk);
    wcs_n = 0; wen = 0; repeat (3) @(negedge wclk); wcs_n = 1;
    settle();
    chk(rd_rdy == 0, "R1", 36'(rd_rdy), 36'd0);
    wr_burst(1); settle();
    @(negedge rclk); rcs_n = 1; ren = 1; repeat (2) @(negedge rclk);
    rcs_n = 0; ren = 0; repeat (2) @(negedge rclk); rcs_n = 1;
    #1;
    chk(rdata == '0, "R1", rdata, '0);
    chk(rd_rdy == 1, "R1", 36'(rd_rdy), 36'd1);
    rd_burst(1, "R2");
    settle();

    // vector table: fill/drain walk, standard timing, offsets 8
    for (int i = 0; i < 10; i++) begin
      int nw, nr;
      nw = int'(VEC[i][19:12]);
      nr = int'(VEC[i][11:4]);
      if (nw > 0) wr_burst(nw);
      if (nr > 0) rd_burst(nr, "R3");
      settle();
      chk_flags(VEC[i][3:0]);
    end

    // R10 retransmit in standard timing
    do_mreset(0, 2'b00);
    wr_burst(5); settle();
    rd_burst(3, "R2");
    @(negedge rclk); rtx_n = 0; @(negedge rclk); rtx_n = 1;
    settle();
    rseq = 0; mcnt = 5;
    rd_burst(5, "R10");
    settle();
    chk(rd_rdy == 0, "R10", 36'(rd_rdy), 36'd0);

    // R7 offset presets
    do_mreset(0, 2'b01);
    wr_burst(16); settle();
    chk(rae_n == 0, "R7", 36'(rae_n), 36'd0);
    wr_burst(1); settle();
    chk(rae_n == 1, "R7", 36'(rae_n), 36'd1);
    chk(waf_n == 1, "R7", 36'(waf_n), 36'd1);
    wr_burst(95); settle();
    chk(waf_n == 0, "R7", 36'(waf_n), 36'd0);
    do_mreset(0, 2'b10);
    wr_burst(64); settle();
    chk(rae_n == 0, "R7", 36'(rae_n), 36'd0);
    wr_burst(1); settle();
    chk(rae_n == 1, "R7", 36'(rae_n), 36'd1);
    chk(waf_n == 0, "R7", 36'(waf_n), 36'd0);

    // R9 partial reset keeps configuration
    rd_burst(1, "R2");
    @(negedge wclk); ofs_sel = 2'b00; prst_n = 0;
    repeat (4) @(posedge rclk);
    @(negedge wclk); prst_n = 1;
    wseq = 0; rseq = 0; mcnt = 0; last_rd = '0;
    settle();
    chk(rdata == '0, "R9", rdata, '0);
    chk({rd_rdy, wr_rdy} == 2'b01, "R9", 36'({rd_rdy, wr_rdy}), 36'd1);
    wr_burst(64); settle();
    chk(rae_n == 0, "R9", 36'(rae_n), 36'd0);
    wr_burst(1); settle();
    chk(rae_n == 1, "R9", 36'(rae_n), 36'd1);
    chk(waf_n == 0, "R9", 36'(waf_n), 36'd0);

    // R4 fall-through timing
    do_mreset(1, 2'b00);
    wr_burst(1); settle();
    chk(rd_rdy == 1, "R4", 36'(rd_rdy), 36'd1);
    chk(rdata == pat(0), "R4", rdata, pat(0));
    wr_burst(3); settle();
    fw_read(4); settle();
    chk(rd_rdy == 0, "R4", 36'(rd_rdy), 36'd0);
    @(negedge rclk); rcs_n = 0; ren = 1; @(negedge rclk); rcs_n = 1; ren = 0;
    settle();
    chk(rdata == last_rd, "R3", rdata, last_rd);
    wr_burst(8); settle();
    chk(rae_n == 0, "R5", 36'(rae_n), 36'd0);
    wr_burst(1); settle();
    chk(rae_n == 1, "R5", 36'(rae_n), 36'd1);

    // R10 retransmit ignored in fall-through timing
    @(negedge rclk); rtx_n = 0; @(negedge rclk); rtx_n = 1;
    settle();
    chk(rdata == pat(rseq), "R10", rdata, pat(rseq));
    fw_read(9); settle();
    chk(rd_rdy == 0, "R10", 36'(rd_rdy), 36'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule